// File: doc/BRIEF.md
# Audio Bit-Clock and Frame-Sync Generator

This block produces the serial bit clock and the frame-sync strobe of an audio port when that port is the clock master. An integer divider turns the source clock into a bit clock. A bit counter then marks out frames whose length is two data words and whose sync pulse covers either a whole word (I2S) or a single bit (DSP-A). When the port is a slave, the block drives nothing. It forwards the externally supplied bit clock and frame sync to its outputs unchanged and holds both output-enables low.

All programmed quantities arrive as the real value minus one. The divider, the frame length and the pulse width are captured into shadow registers. A reprogramming made while the generator runs therefore only takes effect at the next frame boundary, so a frame in flight is never cut short. A divider setting of zero forwards the source clock itself as the bit clock. The generator stays at its idle levels until `gen_en` is raised, and it then opens with the active phase of frame sync.

Top module: `aud_clkgen`

## Requirements
- R1: While reset is asserted, or while `gen_en` is low in master mode, `bclk_o` sits at its idle level (equal to `bclk_inv`) and `fs_o` sits at its inactive level (equal to the inverse of `fs_inv`).
- R2: For `div_m1` = N > 0, the bit clock period is N+1 source cycles, and `bclk_o` spends the first ceil((N+1)/2) of those cycles in its high phase.
- R3: For `div_m1` = 0, while running in master mode, `bclk_o` follows the source clock (XOR `bclk_inv`).
- R4: The frame period is 2*(`wlen_m1`+1) bit clocks.
- R5: With `fmt_dsp` = 0 (I2S), frame sync is active for `wlen_m1`+1 bit clocks at the start of each frame.
- R6: With `fmt_dsp` = 1 (DSP-A), frame sync is active for exactly one bit clock at the start of each frame.
- R7: With `fs_inv` = 0, frame sync is active low; with `fs_inv` = 1, it is active high. With `bclk_inv` = 1, the bit clock is inverted.
- R8: With `master` = 1, both `bclk_oe` and `fs_oe` are 1. With `master` = 0, both are 0, `bclk_o` equals `ext_bclk` and `fs_o` equals `ext_fs`.
- R9: In the first source cycle after the edge that samples `gen_en` high, frame sync is active and the bit clock is in its high phase.
- R10: A change to `div_m1`, `wlen_m1` or `fmt_dsp` while running leaves the current frame unchanged and applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Starts (1) or idles (0) the generator |
| div_m1 | input | DIV_W | Divider ratio minus one |
| wlen_m1 | input | WL_W | Word length in bits minus one |
| fmt_dsp | input | 1 | 0: I2S full-word sync, 1: DSP-A one-bit sync |
| master | input | 1 | 1: drive clocks, 0: forward external clocks |
| bclk_inv | input | 1 | Invert bit clock |
| fs_inv | input | 1 | 1: frame sync active high |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_fs | input | 1 | External frame sync (slave) |
| bclk_o | output | 1 | Bit clock |
| fs_o | output | 1 | Frame sync |
| bclk_oe | output | 1 | Bit clock output-enable |
| fs_oe | output | 1 | Frame sync output-enable |

## Verification
The hardest condition to reach is a reprogramming that lands in the middle of a running frame. The stimulus raises the divider a few source cycles into a frame. It then checks that the remaining bits keep the old bit-clock period and that the next sync pulse is stretched to the new one. The divide-by-one pass-through is checked by sampling both halves of the source clock period, because the bit clock changes inside a single source cycle there.

// File: rtl/aud_clkgen_pkg.sv
package aud_clkgen_pkg;
  localparam int DIV_W = 8;
  localparam int WL_W  = 5;
  localparam int PER_W = WL_W + 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] wid;
  } gen_cfg_t;

  // Frame period minus one: two words of (wlen_m1 + 1) bits.
  function automatic logic [PER_W-1:0] frame_per_m1(input logic [WL_W-1:0] wlen_m1);
    return {wlen_m1, 1'b1};
  endfunction

  // Sync width minus one: full word or one bit.
  function automatic logic [PER_W-1:0] sync_wid_m1(input logic [WL_W-1:0] wlen_m1,
                                                   input logic dsp);
    return dsp ? '0 : {1'b0, wlen_m1};
  endfunction
endpackage

// File: rtl/aud_clkgen_div.sv
module aud_clkgen_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cen,
  input  logic [DIV_W-1:0] div_sh,
  output logic [DIV_W-1:0] dcnt,
  output logic             tick,
  output logic             lvl
);
  logic [DIV_W-1:0] dcnt_q, dcnt_d;

  always_comb begin
    dcnt_d = dcnt_q;
    if (clr)
      dcnt_d = '0;
    else if (cen)
      dcnt_d = (dcnt_q == div_sh) ? '0 : dcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt_q <= '0;
    else        dcnt_q <= dcnt_d;
  end

  assign dcnt = dcnt_q;
  assign tick = cen && !clr && (dcnt_q == div_sh);
  // Divide-by-one forwards the source clock; otherwise high for the first half.
  assign lvl  = (div_sh == '0) ? clk : (dcnt_q <= (div_sh >> 1));
endmodule

// File: rtl/aud_clkgen_frame.sv
module aud_clkgen_frame #(
  parameter int PER_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [PER_W-1:0] per_sh,
  input  logic [PER_W-1:0] wid_sh,
  output logic [PER_W-1:0] bcnt,
  output logic             wrap,
  output logic             fs_act
);
  logic [PER_W-1:0] bcnt_q, bcnt_d;

  always_comb begin
    bcnt_d = bcnt_q;
    if (clr)
      bcnt_d = '0;
    else if (tick)
      bcnt_d = (bcnt_q == per_sh) ? '0 : bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  assign bcnt   = bcnt_q;
  assign wrap   = tick && (bcnt_q == per_sh);
  assign fs_act = (bcnt_q <= wid_sh);
endmodule

// File: rtl/aud_clkgen_shadow.sv
module aud_clkgen_shadow
  import aud_clkgen_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  gen_cfg_t cfg_in,
  output gen_cfg_t cfg_sh
);
  gen_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_sh = cfg_q;
endmodule

// File: rtl/aud_clkgen.sv
module aud_clkgen
  import aud_clkgen_pkg::*;
(
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             gen_en,
  input  logic [DIV_W-1:0] div_m1,
  input  logic [WL_W-1:0]  wlen_m1,
  input  logic             fmt_dsp,
  input  logic             master,
  input  logic             bclk_inv,
  input  logic             fs_inv,
  input  logic             ext_bclk,
  input  logic             ext_fs,
  output logic             bclk_o,
  output logic             fs_o,
  output logic             bclk_oe,
  output logic             fs_oe
);
  logic             run_q, run_d;
  logic             tick, wrap, fs_act, bclk_lvl, load;
  logic [DIV_W-1:0] dcnt;
  logic [PER_W-1:0] bcnt;
  gen_cfg_t         cfg_in, cfg_sh;

  always_comb run_d = gen_en;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_comb begin
    cfg_in.div = div_m1;
    cfg_in.per = frame_per_m1(wlen_m1);
    cfg_in.wid = sync_wid_m1(wlen_m1, fmt_dsp);
  end

  // Shadows follow the inputs while idle and refresh at each frame boundary.
  assign load = !run_q || wrap;

  aud_clkgen_shadow u_shadow (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .load   (load),
    .cfg_in (cfg_in),
    .cfg_sh (cfg_sh)
  );

  aud_clkgen_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .clr    (!gen_en),
    .cen    (run_q),
    .div_sh (cfg_sh.div),
    .dcnt   (dcnt),
    .tick   (tick),
    .lvl    (bclk_lvl)
  );

  aud_clkgen_frame #(.PER_W(PER_W)) u_frame (
    .clk    (clk_src),
    .rst_n  (rst_n),
    .clr    (!gen_en),
    .tick   (tick),
    .per_sh (cfg_sh.per),
    .wid_sh (cfg_sh.wid),
    .bcnt   (bcnt),
    .wrap   (wrap),
    .fs_act (fs_act)
  );

  always_comb begin
    bclk_oe = master;
    fs_oe   = master;
    if (master) begin
      bclk_o = (run_q & bclk_lvl) ^ bclk_inv;
      fs_o   = ~((run_q & fs_act) ^ fs_inv);
    end else begin
      bclk_o = ext_bclk;
      fs_o   = ext_fs;
    end
  end
endmodule

// File: rtl/aud_clkgen_chk.sv
module aud_clkgen_chk
  import aud_clkgen_pkg::*;
(
  input logic             clk_src,
  input logic             rst_n,
  input logic             gen_en,
  input logic             master,
  input logic             bclk_inv,
  input logic             fs_inv,
  input logic             bclk_o,
  input logic             fs_o,
  input logic             run_q,
  input logic             tick,
  input logic             wrap,
  input logic             fs_act,
  input logic [DIV_W-1:0] dcnt,
  input logic [PER_W-1:0] bcnt,
  input gen_cfg_t         cfg_sh
);
  AST_IDLE_LEVELS: assert property (@(posedge clk_src) disable iff (!rst_n)
    (master && !run_q) |-> (fs_o == !fs_inv)); // R1

  AST_DCNT_RANGE: assert property (@(posedge clk_src) disable iff (!rst_n)
    dcnt <= cfg_sh.div); // R2

  AST_BCNT_RANGE: assert property (@(posedge clk_src) disable iff (!rst_n)
    bcnt <= cfg_sh.per); // R4

  AST_FS_ONE_BIT: assert property (@(posedge clk_src) disable iff (!rst_n)
    (gen_en && fs_act && tick && cfg_sh.wid == '0 && cfg_sh.per != '0) |=> !fs_act); // R6

  AST_START_ACTIVE: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!run_q && gen_en) |=> (!gen_en || fs_act)); // R9

  AST_CFG_HOLD: assert property (@(posedge clk_src) disable iff (!rst_n)
    (run_q && gen_en && !wrap) |=> $stable(cfg_sh)); // R10
endmodule

bind aud_clkgen aud_clkgen_chk u_chk (
  .clk_src  (clk_src),
  .rst_n    (rst_n),
  .gen_en   (gen_en),
  .master   (master),
  .bclk_inv (bclk_inv),
  .fs_inv   (fs_inv),
  .bclk_o   (bclk_o),
  .fs_o     (fs_o),
  .run_q    (run_q),
  .tick     (tick),
  .wrap     (wrap),
  .fs_act   (fs_act),
  .dcnt     (dcnt),
  .bcnt     (bcnt),
  .cfg_sh   (cfg_sh)
);

// File: tb/aud_clkgen_tb_top.sv
`timescale 1ns/1ps
module aud_clkgen_tb_top;
  import aud_clkgen_pkg::*;

  logic clk_src = 1'b0;
  logic rst_n;
  logic gen_en, fmt_dsp, master, bclk_inv, fs_inv, ext_bclk, ext_fs;
  logic [DIV_W-1:0] div_m1;
  logic [WL_W-1:0]  wlen_m1;
  logic bclk_o, fs_o, bclk_oe, fs_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NCAP = 128;
  logic fsv [NCAP];
  logic bcv [NCAP];

  always #2.5 clk_src = ~clk_src;

  aud_clkgen dut_i (
    .clk_src(clk_src), .rst_n(rst_n), .gen_en(gen_en), .div_m1(div_m1),
    .wlen_m1(wlen_m1), .fmt_dsp(fmt_dsp), .master(master),
    .bclk_inv(bclk_inv), .fs_inv(fs_inv), .ext_bclk(ext_bclk), .ext_fs(ext_fs),
    .bclk_o(bclk_o), .fs_o(fs_o), .bclk_oe(bclk_oe), .fs_oe(fs_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int run_len(input bit use_fs, input int start, input logic val);
    int n = 0;
    for (int i = start; i < NCAP; i++) begin
      if ((use_fs ? fsv[i] : bcv[i]) !== val) break;
      n++;
    end
    return n;
  endfunction

  task automatic stop_gen();
    @(negedge clk_src);
    gen_en = 1'b0;
    repeat (2) @(negedge clk_src);
  endtask

  // Enable, then capture state one ns after each source edge.
  task automatic capture(input int chg_at, input logic [DIV_W-1:0] new_div);
    @(negedge clk_src);
    gen_en = 1'b1;
    for (int i = 0; i < NCAP; i++) begin
      @(posedge clk_src);
      #1;
      fsv[i] = fs_o;
      bcv[i] = bclk_o;
      if (i == chg_at) div_m1 = new_div;
    end
  endtask

  task automatic t_master(input int d_m1, input int w_m1, input bit dsp,
                          input bit ib, input bit ifs);
    int d, w, wid, a, p;
    d = d_m1 + 1; w = w_m1 + 1; wid = dsp ? 1 : w;
    @(negedge clk_src);
    master = 1; div_m1 = d_m1[DIV_W-1:0]; wlen_m1 = w_m1[WL_W-1:0];
    fmt_dsp = dsp; bclk_inv = ib; fs_inv = ifs;
    @(negedge clk_src); #1;
    chk(bclk_o == ib && fs_o == !ifs, "R1 idle levels", {bclk_o, fs_o}, {ib, !ifs});
    chk(bclk_oe && fs_oe, "R8 master oe", {bclk_oe, fs_oe}, 3);
    capture(-1, '0);
    chk(fsv[0] == ifs, "R9 sync active first", fsv[0], ifs);
    chk(bcv[0] == !ib, "R9 bclk high first", bcv[0], !ib);
    a = run_len(1, 0, ifs);
    chk(a == wid * d, dsp ? "R6 dsp width" : "R5 i2s width", a, wid * d);
    p = a + run_len(1, a, !ifs);
    chk(p == 2 * w * d, "R4 frame period", p, 2 * w * d);
    chk(fsv[p] == ifs, "R7 sync polarity next frame", fsv[p], ifs);
    a = run_len(0, 0, !ib);
    chk(a == (d + 1) / 2, "R2 high phase", a, (d + 1) / 2);
    a = a + run_len(0, a, ib);
    chk(a == d, "R2 bit period", a, d);
    stop_gen();
    #1;
    chk(bclk_o == ib && fs_o == !ifs, "R1 idle after stop", {bclk_o, fs_o}, {ib, !ifs});
  endtask

  task automatic t_passthrough();
    @(negedge clk_src);
    master = 1; div_m1 = '0; wlen_m1 = 5'd3; fmt_dsp = 0; bclk_inv = 0; fs_inv = 0;
    @(negedge clk_src);
    gen_en = 1'b1;
    repeat (3) @(posedge clk_src);
    #1;
    chk(bclk_o == 1'b1, "R3 source high", bclk_o, 1);
    @(negedge clk_src); #1;
    chk(bclk_o == 1'b0, "R3 source low", bclk_o, 0);
    stop_gen();
  endtask

  task automatic t_retune();
    @(negedge clk_src);
    master = 1; div_m1 = 8'd1; wlen_m1 = 5'd1; fmt_dsp = 0; bclk_inv = 0; fs_inv = 0;
    @(negedge clk_src);
    capture(3, 8'd3);
    chk(fsv[3] == 0 && fsv[4] == 1 && fsv[7] == 1, "R10 old frame kept",
        {fsv[3], fsv[4], fsv[7]}, 3'b011);
    chk(bcv[4] == 1 && bcv[5] == 0 && bcv[6] == 1 && bcv[7] == 0, "R10 old divider kept",
        {bcv[4], bcv[5], bcv[6], bcv[7]}, 4'b1010);
    chk(run_len(1, 8, 1'b0) == 8, "R10 new frame width", run_len(1, 8, 1'b0), 8);
    chk(run_len(0, 8, 1'b1) == 2 && bcv[10] == 0 && bcv[11] == 0, "R10 new divider",
        run_len(0, 8, 1'b1), 2);
    stop_gen();
  endtask

  task automatic t_slave();
    @(negedge clk_src);
    master = 0; gen_en = 1; ext_bclk = 1; ext_fs = 0;
    #1;
    chk(!bclk_oe && !fs_oe, "R8 slave oe", {bclk_oe, fs_oe}, 0);
    chk(bclk_o == 1 && fs_o == 0, "R8 slave forward a", {bclk_o, fs_o}, 2);
    ext_bclk = 0; ext_fs = 1;
    repeat (3) @(negedge clk_src);
    #1;
    chk(bclk_o == 0 && fs_o == 1, "R8 slave forward b", {bclk_o, fs_o}, 1);
    stop_gen();
  endtask

  initial begin
    rst_n = 0; gen_en = 0; div_m1 = 8'd3; wlen_m1 = 5'd3; fmt_dsp = 0;
    master = 1; bclk_inv = 0; fs_inv = 0; ext_bclk = 0; ext_fs = 0;
    repeat (3) @(negedge clk_src);
    #1;
    chk(bclk_o == 0 && fs_o == 1, "R1 reset levels", {bclk_o, fs_o}, 1);
    @(negedge clk_src);
    rst_n = 1;
    t_master(3, 3, 0, 0, 0);
    t_master(2, 2, 1, 0, 0);
    t_master(1, 4, 0, 1, 1);
    t_master(3, 2, 1, 1, 0);
    t_passthrough();
    t_retune();
    t_slave();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk_src);
        checks++; errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule